// File: doc/BRIEF.md
# Cycle, Time and Retire Counter Register Bank

This block holds the two 64-bit event counters of a processor hart: one advances on every clock, the other on every clock in which the pipeline reports a retired instruction. It also passes an external 64-bit wall-clock value through to readers. The core reaches all three through one control-register port. The port carries a 12-bit address, a write strobe and write data on the way in, and returns read data together with two flags.

The machine-level addresses can be read and written. The user-level addresses mirror the same values but accept no writes. The parameter `XLEN` picks a 32-bit or a 64-bit core. With a 32-bit core, each 64-bit value is reached as two halves at separate addresses. With a 64-bit core, the high-half addresses do not exist. Reads are combinational and return the counter value as it stands before the coming clock edge. A write takes effect at that clock edge.

Top module: `ctr_csr_bank`

## Requirements
- R1: While reset is asserted, both counters read zero at every address that maps them.
- R2: The cycle counter grows by exactly one per clock in every cycle with no write to address 0xB00 or (XLEN=32) 0xB80.
- R3: The retire counter grows by one in each clock where `retire_i` is high, and holds otherwise, when no write targets it.
- R4: A write to 0xB00 (cycle) or 0xB02 (retire) replaces the low XLEN bits with `csr_wdata_i` and keeps the upper bits. In that cycle the counter does not advance, even if `retire_i` is high.
- R5: With XLEN=32, address 0xB80 (cycle) or 0xB82 (retire) reads bits 63:32. A write there replaces only bits 63:32 and keeps bits 31:0, with no advance in that cycle.
- R6: User aliases return live values. 0xC00 returns cycle, 0xC02 returns retire and 0xC01 returns `time_i`, each in its low XLEN bits. With XLEN=32, 0xC80, 0xC82 and 0xC81 return the matching bits 63:32.
- R7: A write to any user alias address changes no counter, and `csr_illegal_o` is high in that same cycle. A write to a machine address leaves it low.
- R8: Both counters wrap modulo 2^64. A carry out of bit 31 propagates into the upper half.
- R9: Any address not listed in R4 to R6 (including the 0x?8x addresses when XLEN=64) reads zero with `csr_miss_o` high and `csr_illegal_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | One instruction retires this cycle |
| time_i | input | 64 | External wall-clock value |
| csr_addr_i | input | 12 | Register address |
| csr_we_i | input | 1 | Write strobe |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data for `csr_addr_i` |
| csr_miss_o | output | 1 | Address not mapped |
| csr_illegal_o | output | 1 | Write aimed at a read-only alias |

## Verification
The bench builds two instances side by side, one with XLEN=32 and one with XLEN=64, and drives both with the same retire and time inputs. The 32-bit instance exposes half-word access: carries across bit 31, writes to the upper half that keep the lower half, and the high user aliases. The 64-bit instance shows that those same high addresses miss. It also lets a full 64-bit wrap to zero be reached in three clocks, by writing a value just below the limit.

// File: rtl/ctr_csr_bank.sv
module ctr_csr_bank #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            retire_i,
  input  logic [63:0]     time_i,
  input  logic [11:0]     csr_addr_i,
  input  logic            csr_we_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            csr_miss_o,
  output logic            csr_illegal_o
);
  localparam bit          SPLIT   = (XLEN == 32);
  localparam logic [63:0] LO_MASK = SPLIT ? 64'h0000_0000_FFFF_FFFF : '1;

  localparam logic [11:0] M_CYC  = 12'hB00, M_RET  = 12'hB02;
  localparam logic [11:0] M_CYCH = 12'hB80, M_RETH = 12'hB82;
  localparam logic [11:0] U_CYC  = 12'hC00, U_TIM  = 12'hC01, U_RET  = 12'hC02;
  localparam logic [11:0] U_CYCH = 12'hC80, U_TIMH = 12'hC81, U_RETH = 12'hC82;

  logic [63:0] cycle_q, instret_q, cycle_d, instret_d, wd64, sel;
  logic        hit;

  assign wd64 = 64'(csr_wdata_i);

  wire wr_cyc_lo = csr_we_i && csr_addr_i == M_CYC;
  wire wr_cyc_hi = SPLIT && csr_we_i && csr_addr_i == M_CYCH;
  wire wr_ret_lo = csr_we_i && csr_addr_i == M_RET;
  wire wr_ret_hi = SPLIT && csr_we_i && csr_addr_i == M_RETH;

  always_comb begin
    sel = '0;
    hit = 1'b1;
    case (csr_addr_i)
      M_CYC,  U_CYC:  sel = cycle_q;
      M_RET,  U_RET:  sel = instret_q;
      U_TIM:          sel = time_i;
      M_CYCH, U_CYCH: begin sel = cycle_q   >> 32; hit = SPLIT; end
      M_RETH, U_RETH: begin sel = instret_q >> 32; hit = SPLIT; end
      U_TIMH:         begin sel = time_i    >> 32; hit = SPLIT; end
      default:        hit = 1'b0;
    endcase
    if (!hit) sel = '0;
  end

  assign csr_rdata_o   = sel[XLEN-1:0];
  assign csr_miss_o    = !hit;
  assign csr_illegal_o = csr_we_i && hit && csr_addr_i[11:8] == 4'hC;

  always_comb begin
    if (wr_cyc_lo)      cycle_d = (cycle_q & ~LO_MASK) | wd64;
    else if (wr_cyc_hi) cycle_d = {wd64[31:0], cycle_q[31:0]};
    else                cycle_d = cycle_q + 64'd1;

    if (wr_ret_lo)      instret_d = (instret_q & ~LO_MASK) | wd64;
    else if (wr_ret_hi) instret_d = {wd64[31:0], instret_q[31:0]};
    else                instret_d = instret_q + 64'(retire_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycle_q   <= '0;
      instret_q <= '0;
    end else begin
      cycle_q   <= cycle_d;
      instret_q <= instret_d;
    end
  end
endmodule

// File: rtl/ctr_csr_bank_chk.sv
module ctr_csr_bank_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            retire_i,
  input logic [11:0]     csr_addr_i,
  input logic            csr_we_i,
  input logic [XLEN-1:0] csr_wdata_i,
  input logic [XLEN-1:0] csr_rdata_o,
  input logic            csr_miss_o,
  input logic            csr_illegal_o,
  input logic [63:0]     cycle_q,
  input logic [63:0]     instret_q
);
  localparam bit SPLIT = (XLEN == 32);

  logic cyc_wr, ret_wr, ret_wr_lo, cyc_wr_hi, user_wr;
  assign cyc_wr    = csr_we_i && (csr_addr_i == 12'hB00 || (SPLIT && csr_addr_i == 12'hB80));
  assign ret_wr    = csr_we_i && (csr_addr_i == 12'hB02 || (SPLIT && csr_addr_i == 12'hB82));
  assign ret_wr_lo = csr_we_i && csr_addr_i == 12'hB02;
  assign cyc_wr_hi = SPLIT && csr_we_i && csr_addr_i == 12'hB80;
  assign user_wr   = csr_we_i && csr_addr_i[11:8] == 4'hC && !csr_miss_o;

  assert_cycle_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_wr |=> cycle_q == $past(cycle_q) + 64'd1);

  assert_retire_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_wr && retire_i) |=> instret_q == $past(instret_q) + 64'd1);

  assert_retire_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_wr && !retire_i) |=> $stable(instret_q));

  assert_low_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ret_wr_lo |=> instret_q[XLEN-1:0] == $past(csr_wdata_i));

  assert_high_write_keeps_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wr_hi |=> cycle_q[31:0] == $past(cycle_q[31:0]));

  assert_user_write_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    user_wr |-> csr_illegal_o);

  assert_miss_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    csr_miss_o |-> (csr_rdata_o == '0 && !csr_illegal_o));
endmodule

bind ctr_csr_bank ctr_csr_bank_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .csr_addr_i(csr_addr_i),
  .csr_we_i(csr_we_i), .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
  .csr_miss_o(csr_miss_o), .csr_illegal_o(csr_illegal_o),
  .cycle_q(cycle_q), .instret_q(instret_q)
);

// File: tb/ctr_csr_bank_tb_top.sv
`timescale 1ns/1ps
module ctr_csr_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire = 1'b0;
  logic [63:0] time_v = '0;
  logic [11:0] a32 = '0, a64 = '0;
  logic        we32 = 1'b0, we64 = 1'b0;
  logic [31:0] wd32 = '0, rd32;
  logic [63:0] wd64 = '0, rd64;
  logic        miss32, ill32, miss64, ill64;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ctr_csr_bank #(.XLEN(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .retire_i(retire), .time_i(time_v),
    .csr_addr_i(a32), .csr_we_i(we32), .csr_wdata_i(wd32),
    .csr_rdata_o(rd32), .csr_miss_o(miss32), .csr_illegal_o(ill32));

  ctr_csr_bank #(.XLEN(64)) dut64_i (
    .clk(clk), .rst_n(rst_n), .retire_i(retire), .time_i(time_v),
    .csr_addr_i(a64), .csr_we_i(we64), .csr_wdata_i(wd64),
    .csr_rdata_o(rd64), .csr_miss_o(miss64), .csr_illegal_o(ill64));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pair32(input logic [11:0] lo_a, output logic [63:0] v);
    a32 = lo_a;          #1 v[31:0]  = rd32;
    a32 = lo_a + 12'h80; #1 v[63:32] = rd32;
  endtask

  task automatic read64(input logic [11:0] a, output logic [63:0] v);
    a64 = a; #1 v = rd64;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    pair32(12'hB00, v); chk("R1 cycle32", v, 0);
    pair32(12'hB02, v); chk("R1 retire32", v, 0);
    read64(12'hB02, v); chk("R1 retire64", v, 0);
  endtask

  task automatic t_cycle;
    logic [63:0] c0, c1, d0, d1;
    @(negedge clk);
    pair32(12'hB00, c0); read64(12'hB00, d0);
    repeat (5) @(negedge clk);
    pair32(12'hB00, c1); read64(12'hB00, d1);
    chk("R2 cycle32 +5", c1, c0 + 5);
    chk("R2 cycle64 +5", d1, d0 + 5);
  endtask

  task automatic t_retire;
    logic [63:0] i0, i1, j0, j1;
    @(negedge clk);
    pair32(12'hB02, i0); read64(12'hB02, j0);
    retire = 1'b1;
    repeat (3) @(negedge clk);
    retire = 1'b0;
    repeat (2) @(negedge clk);
    pair32(12'hB02, i1); read64(12'hB02, j1);
    chk("R3 retire32 +3", i1, i0 + 3);
    chk("R3 retire64 +3", j1, j0 + 3);
  endtask

  task automatic t_low_write;
    logic [63:0] v, w;
    @(negedge clk);
    pair32(12'hB00, v);
    a32 = 12'hB00; we32 = 1'b1; wd32 = 32'hFFFF_FFF0;
    @(negedge clk); we32 = 1'b0;
    #1 pair32(12'hB00, w);
    chk("R4 cycle low write", w, {v[63:32], 32'hFFFF_FFF0});
    repeat (16) @(negedge clk);
    #1 pair32(12'hB00, w);
    chk("R8 carry into high half", w, {v[63:32] + 32'd1, 32'd0});
  endtask

  task automatic t_retire_write;
    logic [63:0] v, w;
    @(negedge clk);
    pair32(12'hB02, v);
    retire = 1'b1;
    a32 = 12'hB02; we32 = 1'b1; wd32 = 32'h100;
    a64 = 12'hB02; we64 = 1'b1; wd64 = 64'h200;
    @(negedge clk); we32 = 1'b0; we64 = 1'b0; retire = 1'b0;
    #1 pair32(12'hB02, w);
    chk("R4 retire32 write wins", w, {v[63:32], 32'h100});
    read64(12'hB02, w);
    chk("R4 retire64 write wins", w, 64'h200);
  endtask

  task automatic t_high_write;
    logic [63:0] v, w;
    @(negedge clk);
    pair32(12'hB00, v);
    a32 = 12'hB80; we32 = 1'b1; wd32 = 32'hFFFF_FFFF;
    @(negedge clk); we32 = 1'b0;
    #1 pair32(12'hB00, w);
    chk("R5 cycle high write", w, {32'hFFFF_FFFF, v[31:0]});
    @(negedge clk);
    a32 = 12'hB00; we32 = 1'b1; wd32 = 32'hFFFF_FFFF;
    @(negedge clk); we32 = 1'b0;
    #1 pair32(12'hB00, w);
    chk("R4 cycle all ones", w, '1);
    @(negedge clk);
    #1 pair32(12'hB00, w);
    chk("R8 cycle32 wraps", w, 0);
    @(negedge clk);
    pair32(12'hB02, v);
    retire = 1'b1;
    a32 = 12'hB82; we32 = 1'b1; wd32 = 32'hABCD;
    @(negedge clk); we32 = 1'b0; retire = 1'b0;
    #1 pair32(12'hB02, w);
    chk("R5 retire high write", w, {32'hABCD, v[31:0]});
  endtask

  task automatic t_user;
    logic [63:0] m, u;
    @(negedge clk);
    time_v = 64'h0123_4567_89AB_CDEF;
    pair32(12'hB00, m); pair32(12'hC00, u); chk("R6 cycle alias", u, m);
    pair32(12'hB02, m); pair32(12'hC02, u); chk("R6 retire alias", u, m);
    pair32(12'hC01, u); chk("R6 time32", u, 64'h0123_4567_89AB_CDEF);
    read64(12'hC01, u); chk("R6 time64", u, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_user_write;
    logic [63:0] i0, d0, v;
    @(negedge clk);
    retire = 1'b0;
    pair32(12'hB02, i0); read64(12'hB00, d0);
    a32 = 12'hC02; we32 = 1'b1; wd32 = 32'd5;
    a64 = 12'hC00; we64 = 1'b1; wd64 = 64'd0;
    #1 chk("R7 illegal32", ill32, 1);
    chk("R7 illegal64", ill64, 1);
    @(negedge clk); we32 = 1'b0; we64 = 1'b0;
    #1 pair32(12'hB02, v);
    chk("R7 retire unchanged", v, i0);
    read64(12'hB00, v);
    chk("R7 cycle not replaced", v, d0 + 1);
    @(negedge clk);
    a32 = 12'hB00; we32 = 1'b1; wd32 = 32'd0;
    #1 chk("R7 machine write legal", ill32, 0);
    @(negedge clk); we32 = 1'b0;
  endtask

  task automatic t_miss;
    @(negedge clk);
    a32 = 12'h123; #1;
    chk("R9 miss32 flag", miss32, 1); chk("R9 miss32 data", rd32, 0);
    a32 = 12'h123; we32 = 1'b1; #1;
    chk("R9 no illegal on miss", ill32, 0);
    we32 = 1'b0;
    a64 = 12'hB80; #1;
    chk("R9 high addr misses on 64", miss64, 1); chk("R9 miss64 data", rd64, 0);
    a64 = 12'hC81; #1 chk("R9 high time misses on 64", miss64, 1);
    a32 = 12'hB80; #1 chk("R5 high addr hits on 32", miss32, 0);
  endtask

  task automatic t_wrap64;
    logic [63:0] v;
    @(negedge clk);
    a64 = 12'hB00; we64 = 1'b1; wd64 = 64'hFFFF_FFFF_FFFF_FFFE;
    @(negedge clk); we64 = 1'b0;
    #1 read64(12'hB00, v); chk("R4 cycle64 full write", v, 64'hFFFF_FFFF_FFFF_FFFE);
    @(negedge clk);
    #1 read64(12'hB00, v); chk("R8 cycle64 at max", v, '1);
    @(negedge clk);
    #1 read64(12'hB00, v); chk("R8 cycle64 wraps", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_cycle;
    t_retire;
    t_low_write;
    t_retire_write;
    t_high_write;
    t_user;
    t_user_write;
    t_miss;
    t_wrap64;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule